// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32.768 kHz reference, which arrives as a one-cycle enable pulse in the system clock domain, down to a programmable periodic event rate. A 4-bit rate selector picks the division. After the two slowest-coded values are remapped, the period is a power of two of reference ticks. Each time a period runs out, the block emits a single system-clock strobe. A neighbouring flag block consumes that strobe to set its periodic and summary interrupt flags.

The divider runs only while the periodic-interrupt enable is high and the rate selector is non-zero. Dropping the enable, selecting rate 0, or writing any new rate value discards the partial count, so the next strobe falls a complete new period later.

A small state machine controls the block. Its states are `ST_OFF` (divider idle, counter held clear), `ST_COUNT` (counting reference ticks) and `ST_FIRE` (the one-cycle strobe state). The transitions are as follows:
- **ENABLE** goes from `ST_OFF` to `ST_COUNT` when the divider becomes active.
- **EXPIRE** goes from `ST_COUNT` or `ST_FIRE` to `ST_FIRE` on the tick that completes a period.
- **RESUME** goes from `ST_FIRE` to `ST_COUNT` otherwise.
- **RESTART** keeps or returns the machine to `ST_COUNT`, with the counter cleared, when the rate selector changes.
- **DISABLE** goes from any state to `ST_OFF` when the enable is low or the selector is 0.

Top module: `periodic_rate_divider`

## Requirements
- R1: After reset, `period_strobe` is low and the divider is idle. A tick that is counted after reset starts from a zero count.
- R2: With selector values 3 to 15, a strobe follows every 2^(selector-1) counted reference ticks. For example, 3 gives 4 ticks and 15 gives 16384 ticks.
- R3: Selector values 1 and 2 are remapped by adding 7, so they give periods of 128 and 256 ticks.
- R4: Selector value 0 produces no strobe, whatever the enable and the reference ticks do.
- R5: While `pie_en` is low, no strobe is produced and the count is cleared. A reference tick in the first cycle with the enable high again is not counted, so a full period follows re-enabling.
- R6: A cycle in which `rate_code` differs from its value in the previous cycle restarts the count from zero. A tick in that cycle is not counted.
- R7: The strobe is exactly one system clock wide. It is high in the cycle right after the clock edge that samples the period-completing reference tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable marking each 32.768 kHz reference edge |
| rate_code | input | 4 | Rate selector (0 = off, 1/2 remapped, 3..15 direct) |
| pie_en | input | 1 | Periodic-interrupt enable |
| period_strobe | output | 1 | One-cycle strobe at each period expiry |

## Verification
On every cycle, the assertions check four things: the strobe is a single-cycle pulse, it follows a sampled reference tick, it never follows a cycle where the divider was disabled or set to rate 0, and it never follows a rate change. Only the bench's scenarios can show that the period lengths are exact: the power-of-two spacing for direct codes, the 128 and 256 tick periods of the remapped codes, and the full new period after a mid-count disable or rate rewrite. The bench compares each strobe's cycle against a model of the tick count.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } ppi_state_e;

    // Derives the counter width needed for the longest period of a selector width.
    function automatic int cnt_width(input int rate_w);
        return (1 << rate_w) - 1;
    endfunction

endpackage

// File: rtl/ppi_rate_map.sv
module ppi_rate_map #(
    parameter int RATE_W    = 4,
    parameter bit REMAP_EN  = 1'b1,
    parameter int REMAP_MAX = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic [RATE_W-1:0] code_i,
    output logic              active_o,
    output logic [RATE_W-1:0] shift_o
);

    logic [RATE_W-1:0] eff_code;

    generate
        if (REMAP_EN) begin : g_remap
            always_comb begin
                if ((code_i != '0) && (code_i <= RATE_W'(REMAP_MAX)))
                    eff_code = code_i + RATE_W'(REMAP_ADD);
                else
                    eff_code = code_i;
            end
        end else begin : g_direct
            always_comb eff_code = code_i;
        end
    endgenerate

    // Period is 2^(eff_code-1) reference ticks.
    assign active_o = (code_i != '0);
    assign shift_o  = active_o ? (eff_code - RATE_W'(1)) : '0;

endmodule

// File: rtl/ppi_tick_counter.sv
module ppi_tick_counter #(
    parameter int RATE_W = 4,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [RATE_W-1:0] shift_i,
    output logic              expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    assign limit    = (CNT_W'(1) << shift_i) - CNT_W'(1);
    assign at_limit = (cnt_q == limit);
    assign expire_o = inc_i && at_limit && !clr_i;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/ppi_cfg_track.sv
module ppi_cfg_track #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] code_i,
    output logic              changed_o
);

    logic [RATE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else
            code_q <= code_i;
    end

    assign changed_o = (code_i != code_q);

endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
    import ppi_pkg::*;
#(
    parameter int RATE_W    = 4,
    parameter bit REMAP_EN  = 1'b1,
    parameter int REMAP_MAX = 2,
    parameter int REMAP_ADD = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              pie_en,
    output logic              period_strobe
);

    localparam int CNT_W = cnt_width(RATE_W);

    ppi_state_e        state_q, state_d;
    logic              map_active;
    logic [RATE_W-1:0] shift;
    logic              changed;
    logic              active;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              expire;

    ppi_rate_map #(
        .RATE_W   (RATE_W),
        .REMAP_EN (REMAP_EN),
        .REMAP_MAX(REMAP_MAX),
        .REMAP_ADD(REMAP_ADD)
    ) i_rate_map (
        .code_i  (rate_code),
        .active_o(map_active),
        .shift_o (shift)
    );

    ppi_cfg_track #(
        .RATE_W(RATE_W)
    ) i_cfg_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (rate_code),
        .changed_o(changed)
    );

    assign active  = pie_en && map_active;
    assign cnt_clr = (state_q == ST_OFF) || !active || changed;
    assign cnt_inc = ref_tick && (state_q != ST_OFF);

    ppi_tick_counter #(
        .RATE_W(RATE_W),
        .CNT_W (CNT_W)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .shift_i (shift),
        .expire_o(expire)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (active) state_d = ST_COUNT;              // ENABLE
            end
            ST_COUNT, ST_FIRE: begin
                if (!active)      state_d = ST_OFF;          // DISABLE
                else if (changed) state_d = ST_COUNT;        // RESTART
                else if (expire)  state_d = ST_FIRE;         // EXPIRE
                else              state_d = ST_COUNT;        // RESUME
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        period_strobe = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/ppi_checker.sv
module ppi_checker #(
    parameter int RATE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic [RATE_W-1:0] rate_code,
    input logic              pie_en,
    input logic              period_strobe
);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |=> !period_strobe); // R7

    AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> $past(ref_tick)); // R7

    AST_NO_STROBE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> ($past(rate_code) != '0)); // R4

    AST_NO_STROBE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> $past(pie_en)); // R5

    AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code != $past(rate_code)) |=> !period_strobe); // R6

endmodule

bind periodic_rate_divider ppi_checker #(.RATE_W(RATE_W)) i_ppi_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .rate_code    (rate_code),
    .pie_en       (pie_en),
    .period_strobe(period_strobe)
);

// File: tb/test_periodic_rate_divider.sv
module test_periodic_rate_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie_en = 1'b0;
    logic       period_strobe;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    // reference model state
    logic [3:0] m_prev = 4'd0;
    bit         m_armed = 1'b0;
    int         m_cnt = 0;
    string      cur_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    periodic_rate_divider i_periodic_rate_divider (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .rate_code    (rate_code),
        .pie_en       (pie_en),
        .period_strobe(period_strobe)
    );

    function automatic int period_of(input logic [3:0] c);
        int e;
        e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
        return 1 << (e - 1);
    endfunction

    // driver: one cycle of stimulus, model pushes expected strobe cycles
    task automatic step(input logic [3:0] c, input logic en, input logic t);
        bit act;
        @(negedge clk);
        rate_code = c;
        pie_en    = en;
        ref_tick  = t;
        act = en && (c != 4'd0);
        if (!act) begin
            m_cnt = 0;
            m_armed = 1'b0;
        end else if (!m_armed || (c != m_prev)) begin
            m_cnt = 0;
            m_armed = 1'b1;
        end else if (t) begin
            if (m_cnt == period_of(c) - 1) begin
                m_cnt = 0;
                exp_q.push_back(cyc + 1);
                tag_q.push_back(cur_tag);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        m_prev = c;
    endtask

    task automatic ticks(input logic [3:0] c, input logic en, input int n);
        for (int i = 0; i < n; i++) begin
            step(c, en, 1'b1);
            step(c, en, 1'b0);
        end
    endtask

    task automatic phase_end(input string tag);
        for (int i = 0; i < 4; i++) step(rate_code, pie_en, 1'b0);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected strobes outstanding, expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                tests++;
                fails++;
                $display("FAIL %s: strobe missing, actual none, expected at cycle %0d", tag_q[0], exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (period_strobe) begin
                tests++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else begin
                    fails++;
                    $display("FAIL %s: strobe at cycle %0d, expected %0d", cur_tag, cyc,
                             (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run not finished, actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        tests++;
        if (period_strobe !== 1'b0) begin
            fails++;
            $display("FAIL R1: strobe in reset %b, expected 0", period_strobe);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(4'd0, 1'b0, 1'b0);
        tests++;
        if (period_strobe !== 1'b0) begin
            fails++;
            $display("FAIL R1: strobe after reset %b, expected 0", period_strobe);
        end
        phase_end("R1");

        // R2 / R7: direct codes
        cur_tag = "R2";
        step(4'd3, 1'b1, 1'b0);
        ticks(4'd3, 1'b1, 13);
        phase_end("R2");
        step(4'd6, 1'b1, 1'b0);
        ticks(4'd6, 1'b1, 64);
        phase_end("R2");

        // R3: remapped codes
        cur_tag = "R3";
        step(4'd1, 1'b1, 1'b0);
        ticks(4'd1, 1'b1, 130);
        phase_end("R3");
        step(4'd2, 1'b1, 1'b0);
        ticks(4'd2, 1'b1, 258);
        phase_end("R3");

        // R2: slowest code
        cur_tag = "R2";
        step(4'd15, 1'b1, 1'b0);
        ticks(4'd15, 1'b1, 16384);
        phase_end("R2");

        // R4: code 0 gives nothing
        cur_tag = "R4";
        ticks(4'd0, 1'b1, 40);
        phase_end("R4");

        // R5: disable mid-count, re-enable with a tick in the first cycle
        cur_tag = "R5";
        step(4'd3, 1'b1, 1'b0);
        ticks(4'd3, 1'b1, 3);
        ticks(4'd3, 1'b0, 10);
        step(4'd3, 1'b1, 1'b1);
        step(4'd3, 1'b1, 1'b0);
        ticks(4'd3, 1'b1, 5);
        phase_end("R5");

        // R6: rewrite rate mid-count, tick in the change cycle
        cur_tag = "R6";
        step(4'd4, 1'b1, 1'b0);
        ticks(4'd4, 1'b1, 5);
        step(4'd3, 1'b1, 1'b1);
        step(4'd3, 1'b1, 1'b0);
        ticks(4'd3, 1'b1, 6);
        step(4'd5, 1'b1, 1'b1);
        ticks(4'd5, 1'b1, 16);
        phase_end("R6");

        // R7: back-to-back fastest periods, dense ticks
        cur_tag = "R7";
        step(4'd3, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) step(4'd3, 1'b1, 1'b1);
        phase_end("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule